// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block RAM

A synchronous block memory of 4,608 bits with a write port and a read port. Both ports share one clock and run on their own, so a write and a read can happen in the same cycle. Each port picks its own shape: 256x18, 512x9, 1024x4, 2048x2 or 4096x1. Data written at one width can be read back at another, and the block converts it. For example, a nibble written through the 4-bit port comes back as four single bits from the 1-bit port.

The storage is organised as 512 lanes of 9 bits. The narrow shapes (4, 2 and 1 bit) reach only the low 8 bits of each lane. The ninth bit of each lane is reachable only in the 9- and 18-bit shapes. An 18-bit word joins an even lane (low half) and the next odd lane (high half). Width selections are static configuration and change only while both enables are low.

Top module: `mixed_width_bram`

## Requirements
- R1: Mode codes on wrMode/rdMode are 0 = 4096x1, 1 = 2048x2, 2 = 1024x4, 3 = 512x9 and 4 = 256x18. In the 18-bit shape, address a covers lanes 2a (bits 8:0) and 2a+1 (bits 17:9), so a 9-bit read of lane 2a returns the low half of the word written at a.
- R2: 9-bit lanes written one at a time read back joined through the 18-bit shape, with the even lane in bits 8:0.
- R3: In the narrow shapes of width w (1, 2 or 4), address a selects lane a/(8/w), and within it bits [(a mod (8/w))*w +: w]. Lower addresses map to less significant bits. Any write width and any read width can be combined.
- R4: A narrow write never alters a lane's ninth bit (bit 8). The ninth bit is visible only through the 9- and 18-bit shapes.
- R5: Reads are synchronous. rdData changes on the first rising edge after rdEn is sampled high, and holds its value while rdEn is low, even if rdAddr or rdMode change.
- R6: When a read and a write touch the same bits in the same cycle, the read returns the contents from before the write. The new data is visible on the next read.
- R7: rdData bits above the selected read width are zero.
- R8: With wrEn low, or with a write mode code of 5 to 7, no storage bit changes. A read with a mode code of 5 to 7 leaves rdData unchanged.
- R9: Asserting the active-low reset drives rdData to zero. Storage contents are not initialised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rstN | input | 1 | Asynchronous active-low reset of the read output |
| wrEn | input | 1 | Write enable |
| wrMode | input | 3 | Write port shape code |
| wrAddr | input | 12 | Write address, scaled by wrMode |
| wrData | input | 18 | Write data, low bits used in narrow shapes |
| rdEn | input | 1 | Read enable |
| rdMode | input | 3 | Read port shape code |
| rdAddr | input | 12 | Read address, scaled by rdMode |
| rdData | output | 18 | Registered read data |

## Verification
The hardest situation to reach from the ports is a write and a read in the same cycle that overlap only partly and at different widths. An example is a 1-bit write landing inside an 18-bit word that is being read. The bench drives both ports in the same cycle, at matching widths and at mixed widths, and expects the old word. It then re-reads to confirm the new bit. It also crosses every write shape with every read shape on lanes chosen so that each read covers the freshly written bits. Every read is compared against a bit-level reference array that the bench keeps itself.

// File: rtl/mwram_pkg.sv
package mwram_pkg;
  localparam int LANE_BITS = 9;
  localparam int BYTE_BITS = 8;
  localparam int ROW_W     = 8;
  localparam int ROW_CNT   = 1 << ROW_W;
  localparam int LANE_W    = ROW_W + 1;
  localparam int ADDR_W    = ROW_W + 4;
  localparam int DATA_W    = 2 * LANE_BITS;
  localparam int MODE_W    = 3;
  localparam int SUB_W     = 3;

  localparam logic [MODE_W-1:0] MODE_X1  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_X2  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_X4  = 3'd2;
  localparam logic [MODE_W-1:0] MODE_X9  = 3'd3;
  localparam logic [MODE_W-1:0] MODE_X18 = 3'd4;

  typedef struct packed {
    logic [1:0]        wrBankEn;
    logic [ROW_W-1:0]  wrRow;
    logic [SUB_W-1:0]  wrSub;
    logic [MODE_W-1:0] wrMode;
    logic              rdEn;
    logic [ROW_W-1:0]  rdRow;
    logic              rdBank;
    logic [SUB_W-1:0]  rdSub;
    logic [MODE_W-1:0] rdMode;
  } strobe_t;
endpackage

// File: rtl/mwram_ctrl.sv
module mwram_ctrl
  import mwram_pkg::*;
(
  input  logic              wrEn,
  input  logic [MODE_W-1:0] wrMode,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdEn,
  input  logic [MODE_W-1:0] rdMode,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobe_t           strb
);
  localparam int LOC_W = 1 + LANE_W + SUB_W;

  // Result layout: {valid, lane index, sub-word index}
  function automatic logic [LOC_W-1:0] locate(input logic [MODE_W-1:0] m,
                                              input logic [ADDR_W-1:0] a);
    logic [LOC_W-1:0] r;
    r = '0;
    case (m)
      MODE_X18: r = {1'b1, a[ROW_W-1:0], 1'b0, 3'd0};
      MODE_X9:  r = {1'b1, a[LANE_W-1:0], 3'd0};
      MODE_X4:  r = {1'b1, a[LANE_W:1], 2'b00, a[0]};
      MODE_X2:  r = {1'b1, a[LANE_W+1:2], 1'b0, a[1:0]};
      MODE_X1:  r = {1'b1, a[LANE_W+2:3], a[2:0]};
      default:  r = '0;
    endcase
    return r;
  endfunction

  logic [LOC_W-1:0]  wrLoc, rdLoc;
  logic              wrValid, rdValid;
  logic [LANE_W-1:0] wrLane, rdLane;

  always_comb begin
    wrLoc   = locate(wrMode, wrAddr);
    rdLoc   = locate(rdMode, rdAddr);
    wrValid = wrLoc[LOC_W-1];
    rdValid = rdLoc[LOC_W-1];
    wrLane  = wrLoc[SUB_W +: LANE_W];
    rdLane  = rdLoc[SUB_W +: LANE_W];

    strb.wrRow  = wrLane[LANE_W-1:1];
    strb.wrSub  = wrLoc[SUB_W-1:0];
    strb.wrMode = wrMode;
    if (!wrEn || !wrValid)      strb.wrBankEn = 2'b00;
    else if (wrMode == MODE_X18) strb.wrBankEn = 2'b11;
    else if (wrLane[0])          strb.wrBankEn = 2'b10;
    else                         strb.wrBankEn = 2'b01;

    strb.rdEn   = rdEn && rdValid;
    strb.rdRow  = rdLane[LANE_W-1:1];
    strb.rdBank = rdLane[0];
    strb.rdSub  = rdLoc[SUB_W-1:0];
    strb.rdMode = rdMode;
  end
endmodule

// File: rtl/mwram_datapath.sv
module mwram_datapath
  import mwram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [MODE_W-1:0] rdModeQ;
  logic              rdBankQ;
  logic [SUB_W-1:0]  rdSubQ;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [LANE_BITS-1:0] mem [ROW_CNT];
    logic [LANE_BITS-1:0] wd, wm;
    logic [LANE_BITS-1:0] rdWord;

    always_comb begin
      wd = '0;
      wm = '0;
      case (strb.wrMode)
        MODE_X18: begin
          wd = wrData[b*LANE_BITS +: LANE_BITS];
          wm = '1;
        end
        MODE_X9: begin
          wd = wrData[LANE_BITS-1:0];
          wm = '1;
        end
        MODE_X4: begin
          wd = {1'b0, {2{wrData[3:0]}}};
          wm = {1'b0, 8'h0F << {strb.wrSub[0], 2'b00}};
        end
        MODE_X2: begin
          wd = {1'b0, {4{wrData[1:0]}}};
          wm = {1'b0, 8'h03 << {strb.wrSub[1:0], 1'b0}};
        end
        MODE_X1: begin
          wd = {1'b0, {8{wrData[0]}}};
          wm = {1'b0, 8'h01 << strb.wrSub};
        end
        default: begin
          wd = '0;
          wm = '0;
        end
      endcase
    end

    always_ff @(posedge clk) begin
      if (strb.wrBankEn[b]) begin
        for (int i = 0; i < LANE_BITS; i++) begin
          if (wm[i]) mem[strb.wrRow][i] <= wd[i];
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          rdWord <= '0;
      else if (strb.rdEn) rdWord <= mem[strb.rdRow];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdModeQ <= MODE_X18;
      rdBankQ <= 1'b0;
      rdSubQ  <= '0;
    end else if (strb.rdEn) begin
      rdModeQ <= strb.rdMode;
      rdBankQ <= strb.rdBank;
      rdSubQ  <= strb.rdSub;
    end
  end

  logic [LANE_BITS-1:0] selLane;

  always_comb begin
    selLane = rdBankQ ? g_bank[1].rdWord : g_bank[0].rdWord;
    rdData  = '0;
    case (rdModeQ)
      MODE_X18: rdData = {g_bank[1].rdWord, g_bank[0].rdWord};
      MODE_X9:  rdData[LANE_BITS-1:0] = selLane;
      MODE_X4:  rdData[3:0] = selLane[{rdSubQ[0], 2'b00} +: 4];
      MODE_X2:  rdData[1:0] = selLane[{rdSubQ[1:0], 1'b0} +: 2];
      MODE_X1:  rdData[0]   = selLane[rdSubQ];
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/mixed_width_bram.sv
module mixed_width_bram
  import mwram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [MODE_W-1:0] wrMode,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [MODE_W-1:0] rdMode,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  strobe_t strb;

  mwram_ctrl u_ctrl (
    .wrEn   (wrEn),
    .wrMode (wrMode),
    .wrAddr (wrAddr),
    .rdEn   (rdEn),
    .rdMode (rdMode),
    .rdAddr (rdAddr),
    .strb   (strb)
  );

  mwram_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .rdData (rdData)
  );
endmodule

// File: rtl/mwram_checker.sv
module mwram_checker
  import mwram_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [MODE_W-1:0] wrMode,
  input logic              rdEn,
  input logic [MODE_W-1:0] rdMode,
  input logic [DATA_W-1:0] rdData,
  input strobe_t           strb
);
  // R5: output holds while no read is requested
  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  // R8: an unknown read mode code leaves the output alone
  a_r8_bad_read_holds: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdMode > MODE_X18) |=> $stable(rdData));

  // R7: narrow reads drive only their low bits
  a_r7_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdMode <= MODE_X4) |=> (rdData[DATA_W-1:4] == '0));

  // R7: a 9-bit read leaves the high half clear
  a_r7_lane_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdMode == MODE_X9) |=> (rdData[DATA_W-1:LANE_BITS] == '0));

  // R8: no bank is written without a valid write request
  a_r8_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || wrMode > MODE_X18) |-> (strb.wrBankEn == 2'b00));

  // R3: shapes other than 18-bit touch a single bank
  a_r3_single_bank: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrMode != MODE_X18) |-> ($countones(strb.wrBankEn) <= 1));

  // R1: the 18-bit shape writes both lanes of a word
  a_r1_wide_both_banks: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrMode == MODE_X18) |-> (strb.wrBankEn == 2'b11));
endmodule

bind mixed_width_bram mwram_checker u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrMode (wrMode),
  .rdEn   (rdEn),
  .rdMode (rdMode),
  .rdData (rdData),
  .strb   (strb)
);

// File: tb/mixed_width_bram_tb.sv
`timescale 1ns/1ps
module mixed_width_bram_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrMode = 3'd0;
  logic [11:0] wrAddr = '0;
  logic [17:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [2:0]  rdMode = 3'd0;
  logic [11:0] rdAddr = '0;
  logic [17:0] rdData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic refMem [4608];
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  mixed_width_bram u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrMode(wrMode), .wrAddr(wrAddr),
    .wrData(wrData), .rdEn(rdEn), .rdMode(rdMode), .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic int widthOf(input int m);
    case (m) 0: return 1; 1: return 2; 2: return 4; 3: return 9; default: return 18;
    endcase
  endfunction

  function automatic int depthOf(input int m);
    case (m) 0: return 4096; 1: return 2048; 2: return 1024; 3: return 512; default: return 256;
    endcase
  endfunction

  function automatic int bitIndex(input int m, input int a, input int k);
    int w, per;
    w = widthOf(m);
    if (m == 4) return a * 18 + k;
    if (m == 3) return a * 9 + k;
    per = 8 / w;
    return (a / per) * 9 + (a % per) * w + k;
  endfunction

  function automatic logic [17:0] refRead(input int m, input int a);
    logic [17:0] r;
    r = '0;
    for (int k = 0; k < widthOf(m); k++) r[k] = refMem[bitIndex(m, a, k)];
    return r;
  endfunction

  task automatic refWrite(input int m, input int a, input logic [17:0] d);
    for (int k = 0; k < widthOf(m); k++) refMem[bitIndex(m, a, k)] = d[k];
  endtask

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rdData actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doWrite(input int m, input int a, input logic [17:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrMode = 3'(m); wrAddr = 12'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    refWrite(m, a, d);
  endtask

  task automatic readCheck(input string req, input int m, input int a);
    @(negedge clk);
    rdEn = 1'b1; rdMode = 3'(m); rdAddr = 12'(a);
    @(negedge clk);
    rdEn = 1'b0;
    chk(req, rdData, refRead(m, a));
  endtask

  // R9
  task automatic testReset();
    chk("R9 reset output", rdData, 18'h0);
  endtask

  // R1: fill through the 18-bit shape, read back each 9-bit lane
  task automatic testWideToLanes();
    for (int a = 0; a < 256; a++)
      doWrite(4, a, 18'({a[7:0], 2'b01, a[7:0]}) ^ 18'h2_5A5A);
    for (int a = 0; a < 512; a++) readCheck("R1 wide to lane", 3, a);
  endtask

  // R2
  task automatic testLanesToWide();
    doWrite(3, 0, 18'h1FF); doWrite(3, 1, 18'h0A5);
    doWrite(3, 510, 18'h100); doWrite(3, 511, 18'h0FF);
    doWrite(3, 77, 18'h155);
    readCheck("R2 lanes to word", 4, 0);
    readCheck("R2 lanes to word", 4, 255);
    readCheck("R2 lanes to word", 4, 38);
    chk("R2 even lane low", rdData, {9'h155, refRead(3, 76)[8:0]});
  endtask

  // R3 and R4: nibble writes read back as a serial stream
  task automatic testNibbleSerial();
    doWrite(3, 5, 18'h1FF);
    doWrite(2, 10, 18'h3FFFA);
    doWrite(2, 11, 18'h5);
    for (int j = 0; j < 8; j++) begin
      readCheck("R3 serial bit", 0, 40 + j);
    end
    readCheck("R4 ninth bit kept", 3, 5);
    chk("R4 ninth bit value", rdData, 18'h15A);
    for (int j = 0; j < 8; j++) doWrite(0, 48 + j, 18'(j & 1));
    readCheck("R4 ninth bit kept after bit writes", 3, 6);
  endtask

  // R3: every write shape crossed with every read shape
  task automatic testMatrix();
    for (int wm = 0; wm < 5; wm++) begin
      for (int rm = 0; rm < 5; rm++) begin
        for (int n = 0; n < 4; n++) begin
          int a, lane, ra, per;
          logic [31:0] r;
          r = nextRand();
          a = int'(r[19:8]) % depthOf(wm);
          doWrite(wm, a, 18'(nextRand()));
          lane = bitIndex(wm, a, 0) / 9;
          if (rm == 4) ra = lane / 2;
          else if (rm == 3) ra = lane;
          else begin
            per = 8 / widthOf(rm);
            ra = lane * per + int'(r[3:0]) % per;
          end
          readCheck("R3 width cross", rm, ra);
        end
      end
    end
  endtask

  // R5
  task automatic testHold();
    logic [17:0] held;
    readCheck("R5 read", 3, 3);
    held = rdData;
    @(negedge clk);
    rdEn = 1'b1; rdMode = 3'd3; rdAddr = 12'd4;
    #1 chk("R5 no change before edge", rdData, held);
    @(negedge clk);
    rdEn = 1'b0;
    chk("R5 one-cycle latency", rdData, refRead(3, 4));
    held = rdData;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rdAddr = 12'(i * 37); rdMode = 3'(i);
      chk("R5 hold while idle", rdData, held);
    end
  endtask

  // R6
  task automatic testCollision();
    logic [17:0] old;
    old = refRead(4, 7);
    @(negedge clk);
    wrEn = 1'b1; wrMode = 3'd4; wrAddr = 12'd7; wrData = ~old;
    rdEn = 1'b1; rdMode = 3'd4; rdAddr = 12'd7;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    chk("R6 old data on collision", rdData, old);
    refWrite(4, 7, ~old);
    readCheck("R6 new data after", 4, 7);
    old = refRead(4, 7);
    @(negedge clk);
    wrEn = 1'b1; wrMode = 3'd0; wrAddr = 12'(14 * 8 + 2); wrData = {17'h0, ~old[2]};
    rdEn = 1'b1; rdMode = 3'd4; rdAddr = 12'd7;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    chk("R6 mixed width collision", rdData, old);
    refWrite(0, 14 * 8 + 2, {17'h0, ~old[2]});
    readCheck("R6 mixed width new data", 4, 7);
  endtask

  // R8 and R7
  task automatic testIgnored();
    logic [17:0] held;
    @(negedge clk);
    wrEn = 1'b0; wrMode = 3'd4; wrAddr = 12'd20; wrData = 18'h3FFFF;
    @(negedge clk);
    readCheck("R8 disabled write", 4, 20);
    @(negedge clk);
    wrEn = 1'b1; wrMode = 3'd6; wrAddr = 12'd20; wrData = 18'h3FFFF;
    @(negedge clk);
    wrEn = 1'b0;
    readCheck("R8 bad write mode", 4, 20);
    readCheck("R7 narrow upper zero", 1, 100);
    held = rdData;
    @(negedge clk);
    rdEn = 1'b1; rdMode = 3'd7; rdAddr = 12'd21;
    @(negedge clk);
    rdEn = 1'b0;
    chk("R8 bad read mode holds", rdData, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testWideToLanes();
    testLanesToWide();
    testNibbleSerial();
    testMatrix();
    testHold();
    testCollision();
    testIgnored();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule